// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

This block is a real-time-clock core for a register-mapped peripheral. It divides an incoming RTC tick pulse (already in the system clock domain) down to a one-per-second strobe. That strobe advances a free-running 32-bit seconds count and raises a tick flag. A 32-bit alarm value is compared against every new seconds value, and a match raises an alarm flag. Each flag has its own interrupt enable, and the two are combined onto a single interrupt output. A spare scratch word lets software mark whether the time has ever been set.

All writes are guarded twice. First, the block must report itself ready; it drops ready for a fixed number of cycles after each committed write. Second, a key must first be written to an unlock register, and that unlock is spent by the next accepted write. Flags are cleared by writing 0 to their bit. Writing 1 leaves them as they are, so a read-modify-write of the control word never loses an event.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, seconds, alarm, scratch and unlock read 0, control reads 0x80 (only ready set), and the interrupt output is low.
- R2: A write of exactly 0x0000A55A to offset 0x3C, while ready, sets bit 31 of that register. Any other value leaves it clear.
- R3: Writes to offsets 0x00, 0x04, 0x08 and 0x34 take effect only while the unlock bit is set. Each accepted write clears the unlock bit.
- R4: Control bit 7 (ready) reads 0 for exactly WR_BUSY cycles after an accepted write. Every write, including an unlock write, is ignored while it is 0.
- R5: With control bit 0 (run) set, every DIV tick pulses produce one strobe, and each strobe adds 1 to seconds. With run clear, seconds holds and the divider restarts from zero. A seconds write wins over a strobe in the same cycle.
- R6: Each strobe sets control bit 6 (tick flag).
- R7: A control write with 0 in bit 6 or bit 4 clears that flag; a 1 leaves it unchanged. A flag being set in the same cycle wins over its clear.
- R8: With control bit 2 (alarm enable) set, control bit 4 (alarm flag) is set whenever seconds takes a new value, by counting or by a write, that equals the alarm register. With bit 2 clear, no alarm flag is raised.
- R9: The interrupt output equals (bit 6 AND bit 5) OR (bit 4 AND bit 3).
- R10: Seconds wraps from 0xFFFFFFFF to 0 on a strobe.
- R11: Reads of offsets outside 0x00, 0x04, 0x08, 0x34 and 0x3C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle RTC tick pulse |
| wr_i | input | 1 | Write request |
| addr_i | input | 6 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DIV=4 and WR_BUSY=3. With these values, a whole second is four tick pulses, and the ready window is short enough to be checked cycle by cycle. This makes it practical to step the count through several seconds, to walk the alarm match both by counting and by a direct seconds write, and to reach the 32-bit wrap within a few cycles. The interrupt output is swept over every enable pairing for three flag states, and the expected values come from the R9 formula restated in the bench.

// File: rtl/rtc_sa_pkg.sv
package rtc_sa_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SECS   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_SCR    = 6'h34;
  localparam logic [ADDR_W-1:0] OFF_UNLOCK = 6'h3C;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

  localparam int B_READY = 7;
  localparam int B_TFLAG = 6;
  localparam int B_TIE   = 5;
  localparam int B_AFLAG = 4;
  localparam int B_AIE   = 3;
  localparam int B_AEN   = 2;
  localparam int B_RUN   = 0;
  localparam int B_UNLK  = 31;

  // next second, wrapping at the top of the 32-bit range
  function automatic logic [DATA_W-1:0] sec_step(input logic [DATA_W-1:0] s);
    return s + 32'd1;
  endfunction

  function automatic logic irq_calc(input logic tf, input logic tie,
                                    input logic af, input logic aie);
    return (tf & tie) | (af & aie);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input logic rdy, input logic tf,
                                                  input logic tie, input logic af,
                                                  input logic aie, input logic aen,
                                                  input logic run);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_READY] = rdy;
    v[B_TFLAG] = tf;
    v[B_TIE]   = tie;
    v[B_AFLAG] = af;
    v[B_AIE]   = aie;
    v[B_AEN]   = aen;
    v[B_RUN]   = run;
    return v;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic strobe
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign strobe = run & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (tick)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
  import rtc_sa_pkg::*;
#(
  parameter int WR_BUSY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              unlocked,
  output logic              accept
);
  localparam int BW = $clog2(WR_BUSY + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(WR_BUSY);

  logic [BW-1:0] busy_q;
  logic          unlk_q;
  logic          key_hit;

  assign ready    = (busy_q == '0);
  assign unlocked = unlk_q;
  assign key_hit  = wr & ready & (addr == OFF_UNLOCK) & (wdata == UNLOCK_KEY);
  assign accept   = wr & ready & unlk_q & (addr != OFF_UNLOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= '0;
    else if (accept)    busy_q <= BUSY_LOAD;
    else if (!ready)    busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlk_q <= 1'b0;
    else if (accept)    unlk_q <= 1'b0;
    else if (key_hit)   unlk_q <= 1'b1;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strobe,
  output logic [DATA_W-1:0] secs,
  output logic [DATA_W-1:0] alarm,
  output logic [DATA_W-1:0] scratch,
  output logic              tflag,
  output logic              tie,
  output logic              aflag,
  output logic              aie,
  output logic              aen,
  output logic              run,
  output logic              sec_wr,
  output logic              alarm_hit
);
  logic              ctrl_wr, alarm_wr, scr_wr;
  logic              sec_upd;
  logic [DATA_W-1:0] sec_nxt;

  assign ctrl_wr  = accept & (addr == OFF_CTRL);
  assign sec_wr   = accept & (addr == OFF_SECS);
  assign alarm_wr = accept & (addr == OFF_ALARM);
  assign scr_wr   = accept & (addr == OFF_SCR);

  assign sec_upd   = sec_wr | strobe;
  assign sec_nxt   = sec_wr ? wdata : sec_step(secs);
  assign alarm_hit = aen & sec_upd & (sec_nxt == alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        secs <= '0;
    else if (sec_upd)  secs <= sec_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm   <= '0;
      scratch <= '0;
    end else begin
      if (alarm_wr) alarm   <= wdata;
      if (scr_wr)   scratch <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie <= 1'b0;
      aie <= 1'b0;
      aen <= 1'b0;
      run <= 1'b0;
    end else if (ctrl_wr) begin
      tie <= wdata[B_TIE];
      aie <= wdata[B_AIE];
      aen <= wdata[B_AEN];
      run <= wdata[B_RUN];
    end
  end

  // set beats clear; a written 1 keeps the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag <= 1'b0;
      aflag <= 1'b0;
    end else begin
      if (strobe)                         tflag <= 1'b1;
      else if (ctrl_wr && !wdata[B_TFLAG]) tflag <= 1'b0;
      if (alarm_hit)                      aflag <= 1'b1;
      else if (ctrl_wr && !wdata[B_AFLAG]) aflag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_sa_pkg::*;
#(
  parameter int DIV     = 32768,
  parameter int WR_BUSY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              ready, unlocked, accept, strobe;
  logic [DATA_W-1:0] secs, alarm, scratch;
  logic              tflag, tie, aflag, aie, aen, run;
  logic              sec_wr, alarm_hit;

  rtc_wr_gate #(.WR_BUSY(WR_BUSY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr(wr_i), .addr(addr_i), .wdata(wdata_i),
    .ready(ready), .unlocked(unlocked), .accept(accept)
  );

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_i), .strobe(strobe)
  );

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr(addr_i), .wdata(wdata_i),
    .strobe(strobe), .secs(secs), .alarm(alarm), .scratch(scratch),
    .tflag(tflag), .tie(tie), .aflag(aflag), .aie(aie), .aen(aen), .run(run),
    .sec_wr(sec_wr), .alarm_hit(alarm_hit)
  );

  always_comb begin
    unique case (addr_i)
      OFF_CTRL:   rdata_o = ctrl_pack(ready, tflag, tie, aflag, aie, aen, run);
      OFF_SECS:   rdata_o = secs;
      OFF_ALARM:  rdata_o = alarm;
      OFF_SCR:    rdata_o = scratch;
      OFF_UNLOCK: rdata_o = {unlocked, {(DATA_W-1){1'b0}}};
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = irq_calc(tflag, tie, aflag, aie);
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
  import rtc_sa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              accept,
  input logic              ready,
  input logic              unlocked,
  input logic              strobe,
  input logic              sec_wr,
  input logic [DATA_W-1:0] secs,
  input logic [DATA_W-1:0] scratch,
  input logic              tflag,
  input logic              alarm_hit,
  input logic              aflag,
  input logic              tie,
  input logic              aie,
  input logic              irq_o
);
  // R4
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !unlocked);

  // R3
  locked_scratch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == OFF_SCR && !unlocked) |=> $stable(scratch));

  // R6
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> tflag);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sec_wr) |=> (secs == $past(secs) + 32'd1));

  // R8
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> aflag);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tie && !aie) |-> !irq_o);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .accept(accept),
  .ready(ready), .unlocked(unlocked), .strobe(strobe), .sec_wr(sec_wr),
  .secs(secs), .scratch(scratch), .tflag(tflag), .alarm_hit(alarm_hit),
  .aflag(aflag), .tie(tie), .aie(aie), .irq_o(irq_o)
);

// File: tb/rtc_sec_alarm_tb_top.sv
module rtc_sec_alarm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVB  = 4;
  localparam int BUSYB = 3;
  localparam logic [5:0] A_CTRL = 6'h00, A_SECS = 6'h04, A_ALRM = 6'h08,
                         A_SCR = 6'h34, A_UNLK = 6'h3C;
  localparam logic [31:0] KEY = 32'h0000A55A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_sec_alarm #(.DIV(DIVB), .WR_BUSY(BUSYB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    rd(A_CTRL, v);
    while (!v[7]) begin
      @(negedge clk);
      rd(A_CTRL, v);
    end
  endtask

  task automatic sw_write(input logic [5:0] a, input logic [31:0] d);
    wait_ready();
    do_write(A_UNLK, KEY);
    wait_ready();
    do_write(a, d);
    wait_ready();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  function automatic logic exp_irq(input logic tf, input logic te, input logic af, input logic ae);
    return (tf && te) || (af && ae);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  fl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_SECS, v); chk("R1 secs", v, 0);
    rd(A_ALRM, v); chk("R1 alarm", v, 0);
    rd(A_SCR, v);  chk("R1 scratch", v, 0);
    rd(A_UNLK, v); chk("R1 unlock", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h80);
    chk("R1 irq", {31'b0, irq_o}, 0);
    // R11 unmapped offsets
    rd(6'h0C, v); chk("R11 off 0c", v, 0);
    rd(6'h20, v); chk("R11 off 20", v, 0);

    // R2 unlock key
    do_write(A_UNLK, 32'h0000A55B);
    rd(A_UNLK, v); chk("R2 wrong key", v, 0);
    do_write(A_UNLK, KEY);
    rd(A_UNLK, v); chk("R2 key", v, 32'h8000_0000);

    // R3 unlocked write then relock
    do_write(A_SCR, 32'hDEADBEEF);
    wait_ready();
    rd(A_SCR, v);  chk("R3 scratch written", v, 32'hDEADBEEF);
    rd(A_UNLK, v); chk("R3 relocked", v, 0);
    do_write(A_SCR, 32'h11111111);
    wait_ready();
    rd(A_SCR, v);  chk("R3 locked write ignored", v, 32'hDEADBEEF);

    // R4 ready window, cycle by cycle
    do_write(A_UNLK, KEY);
    do_write(A_ALRM, 32'd7);
    for (int k = 0; k <= BUSYB; k++) begin
      rd(A_CTRL, v);
      chk("R4 ready window", {31'b0, v[7]}, (k == BUSYB) ? 1 : 0);
      if (k < BUSYB) @(negedge clk);
    end
    rd(A_ALRM, v); chk("R4 alarm written", v, 7);
    do_write(A_UNLK, KEY);
    do_write(A_ALRM, 32'd9);
    do_write(A_UNLK, KEY);
    wait_ready();
    rd(A_UNLK, v); chk("R4 unlock during busy ignored", v, 0);
    rd(A_ALRM, v); chk("R4 alarm second write", v, 9);

    // R5 counting, R6 tick flag
    sw_write(A_CTRL, 32'h51);
    for (int s = 1; s <= 5; s++) begin
      ticks(DIVB - 1);
      rd(A_SECS, v); chk("R5 before strobe", v, s - 1);
      ticks(1);
      rd(A_SECS, v); chk("R5 after strobe", v, s);
      rd(A_CTRL, v); chk("R6 tick flag", {31'b0, v[6]}, 1);
    end
    sw_write(A_CTRL, 32'h50);
    ticks(2 * DIVB);
    rd(A_SECS, v); chk("R5 halted", v, 5);
    rd(A_CTRL, v); chk("R7 write 1 keeps flag", {31'b0, v[6]}, 1);

    // R7 clear by 0, 1 does not set
    sw_write(A_CTRL, 32'h10);
    rd(A_CTRL, v); chk("R7 tick flag cleared", {31'b0, v[6]}, 0);
    sw_write(A_CTRL, 32'h50);
    rd(A_CTRL, v); chk("R7 write 1 does not set", {31'b0, v[6]}, 0);

    // R8 alarm by counting
    sw_write(A_SECS, 32'd10);
    sw_write(A_ALRM, 32'd12);
    sw_write(A_CTRL, 32'h55);
    ticks(DIVB);
    rd(A_CTRL, v); chk("R8 no match yet", {31'b0, v[4]}, 0);
    ticks(DIVB);
    rd(A_SECS, v); chk("R8 secs at alarm", v, 12);
    rd(A_CTRL, v); chk("R8 alarm flag by count", {31'b0, v[4]}, 1);
    // R8 alarm by seconds write
    sw_write(A_CTRL, 32'h44);
    rd(A_CTRL, v); chk("R7 alarm flag cleared", {31'b0, v[4]}, 0);
    sw_write(A_ALRM, 32'd25);
    rd(A_CTRL, v); chk("R8 alarm write no flag", {31'b0, v[4]}, 0);
    sw_write(A_SECS, 32'd25);
    rd(A_CTRL, v); chk("R8 alarm flag by write", {31'b0, v[4]}, 1);
    // R8 alarm disabled
    sw_write(A_CTRL, 32'h40);
    sw_write(A_SECS, 32'd30);
    sw_write(A_ALRM, 32'd31);
    sw_write(A_CTRL, 32'h41);
    ticks(DIVB);
    rd(A_SECS, v); chk("R8 secs reached", v, 31);
    rd(A_CTRL, v); chk("R8 disabled no flag", {31'b0, v[4]}, 0);

    // R9 interrupt sweep: flags {tf,af} = 11, 01, 00
    sw_write(A_CTRL, 32'h54);
    sw_write(A_ALRM, 32'd40);
    sw_write(A_SECS, 32'd40);
    for (int p = 0; p < 3; p++) begin
      fl = (p == 0) ? 2'b11 : (p == 1) ? 2'b01 : 2'b00;
      if (p == 1) sw_write(A_CTRL, 32'h10);
      if (p == 2) sw_write(A_CTRL, 32'h00);
      for (int e = 0; e < 4; e++) begin
        sw_write(A_CTRL, 32'h50 | (e[1] ? 32'h20 : 0) | (e[0] ? 32'h08 : 0));
        chk("R9 irq", {31'b0, irq_o}, {31'b0, exp_irq(fl[1], e[1], fl[0], e[0])});
      end
    end

    // R10 wrap
    sw_write(A_CTRL, 32'h00);
    sw_write(A_SECS, 32'hFFFF_FFFF);
    sw_write(A_CTRL, 32'h01);
    ticks(DIVB - 1);
    rd(A_SECS, v); chk("R10 at top", v, 32'hFFFF_FFFF);
    ticks(1);
    rd(A_SECS, v); chk("R10 wrapped", v, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule